// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block sits between a simple request interface and a serial flash device. A client issues one high-level request: read, fast read, page program, sector erase, whole-device erase, status read, status write or identification read. The block turns it into the series of SPI command frames the device expects. Modifying requests are preceded by their unlock frame. Program and erase requests are followed by status polling until the device reports it is idle. Address bytes, dummy bytes and data bytes are streamed in the order the device requires.

Write data enters on a valid/ready byte stream. Read data leaves on a valid-only byte stream. A `busy` level covers the whole request, and a one-cycle `done` pulse marks its end. The bit-level shifter is built in and runs SPI mode 0: the clock idles low, the device samples on the rising edge, and the block updates its output after the falling edge. Each system clock cycle is half an SPI bit.

The unlock opcode for status writes is chosen by configuration. So is the program size, either one byte or one page. The erase opcode is selected from four programmable opcodes, one for each erase granularity. All configuration inputs are captured when a request is accepted.

Top module: `flash_seq`

## Requirements
- R1: Read (req_op 0) sends one frame with opcode 03h and three address bytes, most significant first, then clocks req_len+1 data bytes. Each received byte is delivered on rd_data/rd_valid in order.
- R2: Fast read (req_op 1) sends opcode 0Bh, the three address bytes and one dummy byte of 00h, then returns req_len+1 data bytes as in R1.
- R3: Program (req_op 2) sends a 06h frame, then a frame with 02h, the three address bytes and the data bytes taken from wr_data. The number of data bytes is 1 when cfg_page_mode is 0 and PAGE_BYTES (64) when it is 1.
- R4: Sector erase (req_op 3) sends a 06h frame, then a frame with an erase opcode and the three address bytes. The erase opcode is byte cfg_erase_sel of cfg_erase_ops, where bits [8k+7:8k] hold size k (0: 256 B, 1: 4 KB, 2: 8 KB, 3: 64 KB).
- R5: Chip erase (req_op 4) sends a 06h frame followed by a one-byte C7h frame, with no address.
- R6: After the last frame of a program, sector erase or chip erase, the block repeats a frame consisting of 05h plus one received byte. It stops once bit 0 of that byte is 0. Only then does it raise done. The polled bytes never appear on rd_valid.
- R7: Write status (req_op 6) sends a one-byte unlock frame, 50h when cfg_sr_en_alt is 0 and 60h when it is 1. It then sends a frame of 01h followed by one byte from wr_data. No polling follows.
- R8: Read status (req_op 5) sends 05h and returns one byte. Identification read (req_op 7) sends 9Fh and returns three bytes.
- R9: Every command is its own frame with spi_cs_n low, and spi_cs_n is high for at least one cycle between frames. spi_sck is low whenever spi_cs_n is high, and spi_mosi holds steady across each rising spi_sck. Bytes are sent most significant bit first. While the block receives data bytes, it transmits 00h.
- R10: req_ready is high only while idle, and a request offered while busy is ignored. busy stays high from acceptance to done. done is a single-cycle pulse, and busy is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted (idle) |
| req_op | input | 3 | Request type, encoding as in R1 to R8 |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Read byte count minus one |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write data byte offered |
| wr_ready | output | 1 | Write data byte taken |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | rd_data valid for one cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| cfg_sr_en_alt | input | 1 | Status unlock opcode select: 0 gives 50h, 1 gives 60h |
| cfg_page_mode | input | 1 | Program size: 0 gives 1 byte, 1 gives PAGE_BYTES |
| cfg_erase_sel | input | 2 | Erase granularity select |
| cfg_erase_ops | input | 32 | Four programmable erase opcodes |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A wrong frame state shows up on the SPI pins within one frame. The bench records every byte the device sees, grouped by chip-select frame, so a missing unlock frame, a wrong opcode, or a misplaced address or dummy byte is caught at the end of that request. A broken byte or bit counter moves every later byte and breaks the frame length at once. A polling fault shows as the wrong number of 05h frames, or as done arriving while the device still reports itself busy. Received data is compared byte by byte as it appears, so a shifted or reordered sample fails on the first affected byte.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int LEN_W      = 8,
  parameter int PAGE_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  input  logic             cfg_sr_en_alt,
  input  logic             cfg_page_mode,
  input  logic [1:0]       cfg_erase_sel,
  input  logic [31:0]      cfg_erase_ops,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int RD_MAX    = 1 << LEN_W;
  localparam int DAT_MAX   = (RD_MAX > PAGE_BYTES) ? RD_MAX : PAGE_BYTES;
  localparam int IDX_W     = $clog2(DAT_MAX + 6);

  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_FAST  = 3'd1;
  localparam logic [2:0] OP_PROG  = 3'd2;
  localparam logic [2:0] OP_ERASE = 3'd3;
  localparam logic [2:0] OP_CHIP  = 3'd4;
  localparam logic [2:0] OP_RDSR  = 3'd5;
  localparam logic [2:0] OP_WRSR  = 3'd6;
  localparam logic [2:0] OP_ID    = 3'd7;

  typedef enum logic [2:0] {F_IDLE, F_EN, F_MAIN, F_POLL, F_DONE} frame_t;

  frame_t           fr_q, next_fr;
  logic [2:0]       op_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       en_op_q, ers_op_q;
  logic             page_q;
  logic             cs_n_q, sck_q, shifting;
  logic [2:0]       bit_q;
  logic [IDX_W-1:0] idx_q, hdr_n, dat_n;
  logic [7:0]       tx_sh, rx_sh, opcode, byte_val, rd_data_q;
  logic             rd_valid_q, rx_dat, in_data, last_byte, can_start, start, needs_poll;

  assign needs_poll = (op_q == OP_PROG) || (op_q == OP_ERASE) || (op_q == OP_CHIP);

  always_comb begin
    opcode = 8'h05;
    hdr_n  = IDX_W'(1);
    dat_n  = '0;
    rx_dat = 1'b0;
    case (fr_q)
      F_EN:   opcode = en_op_q;
      F_POLL: begin dat_n = IDX_W'(1); rx_dat = 1'b1; end
      F_MAIN: begin
        case (op_q)
          OP_READ:  begin opcode = 8'h03; hdr_n = IDX_W'(4); dat_n = IDX_W'(len_q) + IDX_W'(1); rx_dat = 1'b1; end
          OP_FAST:  begin opcode = 8'h0B; hdr_n = IDX_W'(5); dat_n = IDX_W'(len_q) + IDX_W'(1); rx_dat = 1'b1; end
          OP_PROG:  begin opcode = 8'h02; hdr_n = IDX_W'(4); dat_n = page_q ? IDX_W'(PAGE_BYTES) : IDX_W'(1); end
          OP_ERASE: begin opcode = ers_op_q; hdr_n = IDX_W'(4); end
          OP_CHIP:  opcode = 8'hC7;
          OP_RDSR:  begin opcode = 8'h05; dat_n = IDX_W'(1); rx_dat = 1'b1; end
          OP_WRSR:  begin opcode = 8'h01; dat_n = IDX_W'(1); end
          default:  begin opcode = 8'h9F; dat_n = IDX_W'(3); rx_dat = 1'b1; end
        endcase
      end
      default: ;
    endcase
  end

  assign in_data   = idx_q >= hdr_n;
  assign last_byte = idx_q == (hdr_n + dat_n - IDX_W'(1));

  always_comb begin
    byte_val = 8'h00;
    if (idx_q == '0) byte_val = opcode;
    else if (!in_data) begin
      case (idx_q[2:0])
        3'd1:    byte_val = addr_q[23:16];
        3'd2:    byte_val = addr_q[15:8];
        3'd3:    byte_val = addr_q[7:0];
        default: byte_val = 8'h00;
      endcase
    end else if (!rx_dat) byte_val = wr_data;
  end

  always_comb begin
    case (fr_q)
      F_EN:    next_fr = F_MAIN;
      F_MAIN:  next_fr = needs_poll ? F_POLL : F_DONE;
      F_POLL:  next_fr = rx_sh[0] ? F_POLL : F_DONE;
      default: next_fr = F_DONE;
    endcase
  end

  assign can_start = !cs_n_q && !shifting;
  assign start     = can_start && (!(in_data && !rx_dat) || wr_valid);
  assign wr_ready  = can_start && in_data && !rx_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q       <= F_IDLE;
      op_q       <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      en_op_q    <= 8'h06;
      ers_op_q   <= '0;
      page_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      sck_q      <= 1'b0;
      shifting   <= 1'b0;
      bit_q      <= '0;
      idx_q      <= '0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      case (fr_q)
        F_IDLE: if (req_valid) begin
          op_q     <= req_op;
          addr_q   <= req_addr;
          len_q    <= req_len;
          page_q   <= cfg_page_mode;
          ers_op_q <= cfg_erase_ops[{cfg_erase_sel, 3'b000} +: 8];
          en_op_q  <= (req_op == OP_WRSR) ? (cfg_sr_en_alt ? 8'h60 : 8'h50) : 8'h06;
          fr_q     <= (req_op == OP_PROG || req_op == OP_ERASE || req_op == OP_CHIP ||
                       req_op == OP_WRSR) ? F_EN : F_MAIN;
        end
        F_DONE: fr_q <= F_IDLE;
        default: begin
          if (cs_n_q) begin
            cs_n_q <= 1'b0;
            idx_q  <= '0;
          end else if (start) begin
            tx_sh    <= byte_val;
            shifting <= 1'b1;
            bit_q    <= '0;
          end else if (shifting) begin
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx_sh <= {rx_sh[6:0], spi_miso};
            end else begin
              sck_q <= 1'b0;
              if (bit_q == 3'd7) begin
                shifting <= 1'b0;
                idx_q    <= idx_q + IDX_W'(1);
                if (rx_dat && in_data && fr_q == F_MAIN) begin
                  rd_valid_q <= 1'b1;
                  rd_data_q  <= rx_sh;
                end
                if (last_byte) begin
                  cs_n_q <= 1'b1;
                  fr_q   <= next_fr;
                end
              end else begin
                bit_q <= bit_q + 3'd1;
                tx_sh <= {tx_sh[6:0], 1'b0};
              end
            end
          end
        end
      endcase
    end
  end

  assign req_ready = fr_q == F_IDLE;
  assign busy      = fr_q != F_IDLE;
  assign done      = fr_q == F_DONE;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign spi_cs_n  = cs_n_q;
  assign spi_sck   = sck_q;
  assign spi_mosi  = shifting ? tx_sh[7] : 1'b0;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic rd_valid,
  input logic wr_ready,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi
);
  a_r9_sck_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r9_mosi_steady_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi));

  a_r10_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);

  a_r10_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r1_rdata_within_request: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  a_r3_wdata_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (busy && !spi_cs_n && !spi_sck));
endmodule

bind flash_seq flash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_valid(rd_valid),
  .wr_ready(wr_ready), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/flash_seq_tb.sv
module flash_seq_tb;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_ready;
  logic [2:0] req_op = 0;
  logic [23:0] req_addr = 0;
  logic [7:0] req_len = 0;
  logic [7:0] wr_data = 0;
  logic wr_valid = 0, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, busy, done;
  logic cfg_sr_en_alt = 0, cfg_page_mode = 0;
  logic [1:0] cfg_erase_sel = 0;
  logic [31:0] cfg_erase_ops = {8'h42, 8'h20, 8'h52, 8'hD8};
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 0;

  flash_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
    .cfg_sr_en_alt(cfg_sr_en_alt), .cfg_page_mode(cfg_page_mode),
    .cfg_erase_sel(cfg_erase_sel), .cfg_erase_ops(cfg_erase_ops),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int errors = 0, checks = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  // ---------------- flash model ----------------
  logic [8:0]  log_q[$];
  logic [7:0]  m_shift = 0, m_out = 0, m_op = 0, sr = 0;
  logic [23:0] m_addr = 0;
  int m_bits = 0, m_idx = 0, busy_left = 0;
  logic [7:0] id_b[3] = '{8'hEF, 8'h40, 8'h17};

  function automatic void got_byte(input logic [7:0] b);
    m_out = 8'h00;
    if (m_idx == 0) begin m_op = b; log_q.push_back({1'b1, b}); end
    else log_q.push_back({1'b0, b});
    if (m_idx >= 1 && m_idx <= 3) m_addr = {m_addr[15:0], b};
    case (m_op)
      8'h03: if (m_idx >= 3) m_out = pat(m_addr + 24'(m_idx - 3));
      8'h0B: if (m_idx >= 4) m_out = pat(m_addr + 24'(m_idx - 4));
      8'h05: if (m_idx == 0) begin
        if (busy_left > 0) begin m_out = 8'h01; busy_left--; end
        else m_out = sr;
      end
      8'h9F: if (m_idx <= 2) m_out = id_b[m_idx];
      8'h01: if (m_idx == 1) sr = b;
      default: ;
    endcase
  endfunction

  always @(negedge spi_cs_n) begin m_bits = 0; m_idx = 0; m_out = 0; spi_miso = 0; end
  always @(posedge spi_cs_n)
    if (m_op inside {8'h02, 8'hC7, 8'hD8, 8'h52, 8'h20, 8'h42}) begin busy_left = 2; m_op = 0; end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    m_shift = {m_shift[6:0], spi_mosi};
    m_bits++;
    if (m_bits == 8) begin m_bits = 0; got_byte(m_shift); m_idx++; end
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    spi_miso = m_out[7];
    m_out = {m_out[6:0], 1'b0};
  end

  // ---------------- write source ----------------
  logic [7:0] wr_src[$];
  always @(negedge clk) begin
    wr_valid <= wr_src.size() > 0;
    wr_data  <= (wr_src.size() > 0) ? wr_src[0] : 8'h00;
  end
  always @(posedge clk) if (wr_valid && wr_ready) void'(wr_src.pop_front());

  // ---------------- scoreboard ----------------
  logic [7:0] exp_rd[$];
  logic [8:0] exp_log[$];

  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_rd.size() == 0) chk(0, {tag, " unexpected read byte"}, rd_data, 0);
    else begin
      logic [7:0] e;
      e = exp_rd.pop_front();
      chk(rd_data == e, {tag, " read byte"}, rd_data, e);
    end
  end

  task automatic ef(input logic [7:0] b); exp_log.push_back({1'b1, b}); endtask
  task automatic eb(input logic [7:0] b); exp_log.push_back({1'b0, b}); endtask
  task automatic ea(input logic [23:0] a); eb(a[23:16]); eb(a[15:8]); eb(a[7:0]); endtask
  task automatic epoll();
    for (int i = 0; i < 3; i++) begin ef(8'h05); eb(8'h00); end
  endtask

  task automatic run(input logic [2:0] op, input logic [23:0] addr, input logic [7:0] len, input bit hold);
    log_q.delete();
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = addr; req_len = len;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1, "R10 busy after accept", busy, 1);
    if (hold) begin
      repeat (20) @(negedge clk);
      req_valid = 1; req_op = 3'd4;
      chk(req_ready == 0, "R10 ready low while busy", req_ready, 0);
      repeat (5) @(negedge clk);
      req_valid = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy == 0 && done == 0, "R10 idle after done", {busy, done}, 0);
    repeat (40) @(negedge clk);
    begin
      int mi = -1;
      for (int i = 0; i < exp_log.size() && i < log_q.size(); i++)
        if (mi < 0 && log_q[i] !== exp_log[i]) mi = i;
      if (mi < 0 && log_q.size() != exp_log.size())
        chk(0, {tag, " R9 frame length"}, log_q.size(), exp_log.size());
      else if (mi >= 0)
        chk(0, {tag, " R9 frame byte"}, {mi[15:0], 7'd0, log_q[mi]}, {mi[15:0], 7'd0, exp_log[mi]});
      else chk(1, tag, 0, 0);
    end
    chk(exp_rd.size() == 0, {tag, " missing read bytes"}, exp_rd.size(), 0);
    chk(wr_src.size() == 0, {tag, " write bytes left"}, wr_src.size(), 0);
    exp_log.delete();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1 && spi_sck == 0, "R9 reset pins", {spi_cs_n, spi_sck}, 2);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && rd_valid == 0, "R10 reset state", {busy, done, rd_valid}, 0);
    chk(req_ready == 1, "R10 ready at reset", req_ready, 1);

    // R1 plain read, 4 bytes
    tag = "R1";
    ef(8'h03); ea(24'h123456); for (int i = 0; i < 4; i++) eb(8'h00);
    for (int i = 0; i < 4; i++) exp_rd.push_back(pat(24'h123456 + 24'(i)));
    run(3'd0, 24'h123456, 8'd3, 0);

    // R2 fast read with dummy, crossing a 64K boundary
    tag = "R2";
    ef(8'h0B); ea(24'h00FFFE); eb(8'h00); for (int i = 0; i < 3; i++) eb(8'h00);
    for (int i = 0; i < 3; i++) exp_rd.push_back(pat(24'h00FFFE + 24'(i)));
    run(3'd1, 24'h00FFFE, 8'd2, 0);

    // R7 write status, both unlock opcodes
    tag = "R7";
    cfg_sr_en_alt = 0;
    ef(8'h50); ef(8'h01); eb(8'h3C); wr_src.push_back(8'h3C);
    run(3'd6, 0, 0, 0);
    cfg_sr_en_alt = 1;
    ef(8'h60); ef(8'h01); eb(8'h3C); wr_src.push_back(8'h3C);
    run(3'd6, 0, 0, 0);

    // R8 status read and identification
    tag = "R8";
    ef(8'h05); eb(8'h00); exp_rd.push_back(8'h3C);
    run(3'd5, 0, 0, 0);
    ef(8'h9F); eb(0); eb(0); eb(0);
    exp_rd.push_back(8'hEF); exp_rd.push_back(8'h40); exp_rd.push_back(8'h17);
    run(3'd7, 0, 0, 0);

    // R3 R6 single byte program
    tag = "R3";
    cfg_page_mode = 0;
    ef(8'h06); ef(8'h02); ea(24'h000100); eb(8'hAB); epoll();
    wr_src.push_back(8'hAB);
    run(3'd2, 24'h000100, 0, 0);

    // R3 R6 R10 page program with a request offered while busy
    tag = "R3";
    cfg_page_mode = 1;
    ef(8'h06); ef(8'h02); ea(24'h010000);
    for (int i = 0; i < 64; i++) begin eb(8'(i * 3)); wr_src.push_back(8'(i * 3)); end
    epoll();
    run(3'd2, 24'h010000, 0, 1);

    // R4 R6 erase at each granularity
    tag = "R4";
    for (int s = 0; s < 4; s++) begin
      cfg_erase_sel = 2'(s);
      ef(8'h06); ef(cfg_erase_ops[s*8 +: 8]); ea(24'h012000); epoll();
      run(3'd3, 24'h012000, 0, 0);
    end

    // R5 R6 chip erase
    tag = "R5";
    ef(8'h06); ef(8'hC7); epoll();
    run(3'd4, 24'hFFFFFF, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule